// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter Stage

This block is one four-bit stage of a synchronous up-counter. Every state bit is updated on the same rising clock edge. At build time the stage is set up either as a binary counter that runs through sixteen states or as a decade counter that runs through ten. A second build-time choice decides how the active-low clear acts. In one setting it clears at the next rising edge. In the other it clears at once, with no clock needed. The stage can also be preset: a parallel load copies the data inputs into the count.

The stage has two count enables with different jobs. Both must be high for the count to advance. Only the second one, the carry-enable, also gates the carry output. That output is a decoded terminal-count carry and has no clock delay. It goes high when the carry-enable is high and the stage sits at its last state. To build a wider counter, feed each stage's carry into the carry-enable of the stage above it, and tie the advance-enables of all stages to one common signal. The chain then steps as a single wide synchronous counter, with no extra gating.

Top module: `sync_counter_stage`

## Requirements
- R1: The count changes only on a rising clock edge, apart from an asynchronous clear. A change on load or on either enable between edges leaves `count_q` unchanged until the next edge.
- R2: While `clear_n` is low, `count_q` becomes 0. Clear wins over load and over both enables. With the synchronous clear setting, the zero appears only after the next rising edge.
- R3: With the asynchronous clear setting, `count_q` reads 0 as soon as `clear_n` falls, before any clock edge.
- R4: With `clear_n` high and `load_n` low, the next rising edge copies `preset_d` into `count_q`, whatever the levels of both enables.
- R5: With `clear_n` and `load_n` high, and both `en_p` and `en_t` high, each rising edge adds one to a count that is below the terminal value.
- R6: With `clear_n` and `load_n` high and either enable low, the count holds.
- R7: A counting edge taken at the terminal value returns the count to 0. The terminal value is 15 in binary mode and 9 in decade mode.
- R8: `carry_out` is high exactly when `en_t` is high and `count_q` equals the terminal value. It follows those inputs with no clock delay and does not depend on `en_p`.
- R9: In decade mode, a loaded value from 10 to 15 goes to 0 on the next counting edge, and `carry_out` stays low while the count holds such a value.
- R10: Two stages chained carry-to-`en_t`, with a shared `en_p`, count as one 8-bit binary counter. The upper stage advances only on the edge where the lower stage wraps, so 0xFF steps to 0x00.
- R11: In binary mode with synchronous clear, if an external decode of count 11 drives `clear_n`, the count cycle shortens to twelve states: 0 through 11, then back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Active-low clear, synchronous or asynchronous by parameter |
| load_n | input | 1 | Active-low parallel load, applied at the next rising edge |
| preset_d | input | WIDTH | Value copied into the count on a load |
| en_p | input | 1 | Advance-enable; does not gate the carry |
| en_t | input | 1 | Carry-enable; gates both counting and the carry output |
| count_q | output | WIDTH | Current count |
| carry_out | output | 1 | Decoded terminal-count carry for chaining |

## Verification
The bench goes after the edges where control inputs fight each other. Clear is applied together with load, so a design with the priority the wrong way round would load instead of clearing. Clear and load are also changed halfway through a cycle: a synchronous stage that reacted early, or an asynchronous stage that waited for the clock, shows the wrong count before the edge. The carry is checked with `en_p` low at the terminal value, and with out-of-range decade values loaded. A carry gated by the wrong enable, or decoded from the upper bits only, would then assert where it must not. A two-stage chain rolling past 0xFF, and a stage shortened to modulus twelve by its own decode, expose an upper stage that steps on every edge and a clear that lands one cycle late.

// File: rtl/cnt_pkg.sv
// Shared types and helpers for the counter stage.
// Assumes the decade setting is only used with WIDTH of at least 4.
package cnt_pkg;

    typedef enum logic {
        CNT_BINARY = 1'b0,
        CNT_DECADE = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clr_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Last state of the counting cycle for a given mode and width.
    function automatic int unsigned terminal_count(cnt_mode_e mode, int unsigned width);
        if (mode == CNT_DECADE) begin
            return 9;
        end
        return (32'd1 << width) - 32'd1;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
// Turns the control pins into one operation for the coming edge.
// Priority: clear, then load, then count (both enables high), else hold.
// Assumes all controls are stable around the rising edge.
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    clear_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // Priority encode of the mode controls.
    always_comb begin
        if (!clear_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_next_value.sv
// Works out the next count from the chosen operation.
// Any value at or above TERM goes to zero on a count, which keeps
// out-of-range decade values one step away from the valid cycle.
module cnt_next_value
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned TERM  = 15
) (
    input  cnt_op_e            op,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   preset,
    output logic [WIDTH-1:0]   nxt
);

    localparam logic [WIDTH-1:0] TERM_Q = TERM[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE_Q  = WIDTH'(1);

    // Select clear, load, increment-with-wrap or hold.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = (cur >= TERM_Q) ? '0 : cur + ONE_Q;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_state_reg.sv
// State register of the stage. CLR_MODE picks a clear that acts at the
// next edge or one that acts at once. Assumes clear_n is free of glitches.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter clr_mode_e   CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async_clear
            // Register with clear that does not wait for the clock.
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end else begin : g_sync_clear
            // Register with clear sampled on the rising edge.
            always_ff @(posedge clk) begin
                if (!clear_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cnt_carry_decode.sv
// Decoded terminal-count carry. Combinational from the state and the
// carry-enable only, so a chain of stages adds no clock delay.
module cnt_carry_decode #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned TERM  = 15
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TERM_Q = TERM[WIDTH-1:0];

    // Carry asserts at the terminal value when carry-enable is high.
    always_comb begin
        carry = en_t && (q == TERM_Q);
    end

endmodule

// File: rtl/sync_counter_stage.sv
// One cascadable synchronous counter stage with preset.
// MODE picks binary or decade counting; CLR_MODE picks the clear timing.
// Assumes the carry of a lower stage drives en_t of this one when chained.
module sync_counter_stage
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter cnt_mode_e   MODE     = CNT_BINARY,
    parameter clr_mode_e   CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_d,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_out
);

    localparam int unsigned TERM = terminal_count(MODE, WIDTH);

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    cnt_op_decode u_op_decode (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .op      (op)
    );

    cnt_next_value #(
        .WIDTH (WIDTH),
        .TERM  (TERM)
    ) u_next_value (
        .op     (op),
        .cur    (count_q),
        .preset (preset_d),
        .nxt    (nxt)
    );

    cnt_state_reg #(
        .WIDTH    (WIDTH),
        .CLR_MODE (CLR_MODE)
    ) u_state_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .nxt     (nxt),
        .q       (count_q)
    );

    cnt_carry_decode #(
        .WIDTH (WIDTH),
        .TERM  (TERM)
    ) u_carry_decode (
        .q     (count_q),
        .en_t  (en_t),
        .carry (carry_out)
    );

endmodule

// File: rtl/cnt_stage_checks.sv
// Property checks for sync_counter_stage, bound to every instance.
// Assumes inputs settle away from the rising edge.
module cnt_stage_checks
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter cnt_mode_e   MODE  = CNT_BINARY
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load_n,
    input logic [WIDTH-1:0] preset_d,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] count_q,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] TERM_Q = WIDTH'(terminal_count(MODE, WIDTH));
    localparam logic [WIDTH-1:0] ONE_Q  = WIDTH'(1);

    logic armed = 1'b0;

    // Enable the properties once a first edge has passed.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> (count_q == '0));

    assert_load_preset_R4: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> (!clear_n || count_q == $past(preset_d)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && en_p && en_t && count_q < TERM_Q)
        |=> (!clear_n || count_q == $past(count_q) + ONE_Q));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !(en_p && en_t)) |=> (!clear_n || $stable(count_q)));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && en_p && en_t && count_q >= TERM_Q)
        |=> (count_q == '0));

    assert_carry_gate_R8: assert property (@(posedge clk) disable iff (!armed)
        carry_out |-> (en_t && count_q == TERM_Q));

    assert_carry_seen_R8: assert property (@(posedge clk) disable iff (!armed)
        (en_t && count_q == TERM_Q) |-> carry_out);

    assert_no_carry_out_of_range_R9: assert property (@(posedge clk) disable iff (!armed)
        (count_q > TERM_Q) |-> !carry_out);

endmodule

bind sync_counter_stage cnt_stage_checks #(
    .WIDTH (WIDTH),
    .MODE  (MODE)
) u_stage_checks (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .preset_d  (preset_d),
    .en_p      (en_p),
    .en_t      (en_t),
    .count_q   (count_q),
    .carry_out (carry_out)
);

// File: tb/sync_counter_stage_bench.sv
// Bench: a two-stage binary chain, a decade stage with async clear and a
// binary stage shortened to modulus twelve, each against a behavioural model.
module sync_counter_stage_bench;
    import cnt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // chain of two binary stages, synchronous clear
    logic       c_clr_n = 1'b0, c_load_n = 1'b1, c_p = 1'b0, c_t = 1'b0;
    logic [3:0] c_d_lo = '0, c_d_hi = '0;
    logic [3:0] c_q_lo, c_q_hi;
    logic       c_co_lo, c_co_hi;

    // decade stage, asynchronous clear
    logic       d_clr_n = 1'b0, d_load_n = 1'b1, d_p = 1'b0, d_t = 1'b0;
    logic [3:0] d_d = '0;
    logic [3:0] d_q;
    logic       d_co;

    // binary stage cleared by a decode of count 11
    logic       s_rst_n = 1'b0, s_en = 1'b0;
    logic       s_clr_n;
    logic [3:0] s_q;
    logic       s_co;
    assign s_clr_n = s_rst_n && (s_q != 4'd11);

    sync_counter_stage u_sync_counter_stage (
        .clk (clk), .clear_n (c_clr_n), .load_n (c_load_n), .preset_d (c_d_lo),
        .en_p (c_p), .en_t (c_t), .count_q (c_q_lo), .carry_out (c_co_lo)
    );

    sync_counter_stage u_sync_counter_stage_hi (
        .clk (clk), .clear_n (c_clr_n), .load_n (c_load_n), .preset_d (c_d_hi),
        .en_p (c_p), .en_t (c_co_lo), .count_q (c_q_hi), .carry_out (c_co_hi)
    );

    sync_counter_stage #(
        .MODE (CNT_DECADE), .CLR_MODE (CLR_ASYNC)
    ) u_sync_counter_stage_dec (
        .clk (clk), .clear_n (d_clr_n), .load_n (d_load_n), .preset_d (d_d),
        .en_p (d_p), .en_t (d_t), .count_q (d_q), .carry_out (d_co)
    );

    sync_counter_stage u_sync_counter_stage_mod (
        .clk (clk), .clear_n (s_clr_n), .load_n (1'b1), .preset_d (4'd0),
        .en_p (s_en), .en_t (1'b1), .count_q (s_q), .carry_out (s_co)
    );

    // behavioural model state
    int    m_lo = 0, m_hi = 0, m_dq = 0, m_sq = 0;
    int    n_lo;
    bit    lo_carry;
    string tag_lo = "R2", tag_hi = "R2", tag_dq = "R2", tag_sq = "R2", tag_tmp;

    function automatic int model_step(bit clr, bit ld, int d, bit p, bit t,
                                      int q, int term, output string tag);
        if (!clr) begin
            tag = "R2";  return 0;
        end
        if (!ld) begin
            tag = "R4";  return d;
        end
        if (p && t) begin
            if (q > term)  begin tag = "R9"; return 0; end
            if (q == term) begin tag = "R7"; return 0; end
            tag = "R5";  return q + 1;
        end
        tag = "R6";
        return q;
    endfunction

    // Advance every model on the rising edge from the inputs held there.
    always @(posedge clk) begin
        lo_carry = c_t && (m_lo == 15);
        n_lo = model_step(c_clr_n, c_load_n, int'(c_d_lo), c_p, c_t, m_lo, 15, tag_lo);
        m_hi = model_step(c_clr_n, c_load_n, int'(c_d_hi), c_p, lo_carry, m_hi, 15, tag_tmp);
        tag_hi = "R10";
        m_lo = n_lo;
        m_dq = model_step(d_clr_n, d_load_n, int'(d_d), d_p, d_t, m_dq, 9, tag_dq);
        m_sq = model_step(s_rst_n && (m_sq != 11), 1'b1, 0, s_en, 1'b1, m_sq, 15, tag_tmp);
        tag_sq = "R11";
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_d;
        exp_d = d_clr_n ? m_dq : 0;
        check(tag_lo, int'(c_q_lo), m_lo);
        check(tag_hi, int'(c_q_hi), m_hi);
        check("R8 low carry", int'(c_co_lo), int'(c_t && m_lo == 15));
        check("R10 high carry", int'(c_co_hi), int'(c_t && m_lo == 15 && m_hi == 15));
        check(tag_dq, int'(d_q), exp_d);
        check("R8 decade carry", int'(d_co), int'(d_t && exp_d == 9));
        check(tag_sq, int'(s_q), m_sq);
        check("R11 no carry", int'(s_co), int'(m_sq == 15));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // Ends a hung run as a failure.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (2) tick();                      // reset state, R2
        c_clr_n = 1'b1; d_clr_n = 1'b1; s_rst_n = 1'b1; s_en = 1'b1;

        // R4: load with both enables low
        c_load_n = 1'b0; c_d_lo = 4'hD; c_d_hi = 4'hF;
        tick();
        c_load_n = 1'b1; c_p = 1'b1; c_t = 1'b1;
        repeat (40) tick();                     // R5, R7, R10 across 0xFF
        c_p = 1'b0;
        repeat (3) tick();                      // R6 hold with en_p low

        // R8: carry with en_p low at terminal value
        c_load_n = 1'b0; c_d_lo = 4'hF; c_d_hi = 4'h3;
        tick();
        c_load_n = 1'b1;
        repeat (2) tick();
        c_p = 1'b1; c_t = 1'b0;
        repeat (3) tick();                      // R6 hold with en_t low
        c_t = 1'b1;
        tick();

        // R1: load change between edges leaves the count alone
        c_load_n = 1'b0; c_d_lo = 4'h5;
        #1 check("R1 mid-cycle load", int'(c_q_lo), m_lo);
        tick();
        c_load_n = 1'b1;
        repeat (3) tick();

        // R2: synchronous clear beats load, waits for the edge
        c_clr_n = 1'b0; c_load_n = 1'b0;
        #1 check("R2 sync clear waits", int'(c_q_lo), m_lo);
        tick();
        c_clr_n = 1'b1; c_load_n = 1'b1;
        s_en = 1'b0;
        repeat (3) tick();                      // R6 on the modulus stage
        s_en = 1'b1;

        // decade stage: R5, R7, R8
        d_p = 1'b1; d_t = 1'b1;
        repeat (25) tick();
        d_p = 1'b0; d_load_n = 1'b0; d_d = 4'd9;
        tick();
        d_load_n = 1'b1;
        tick();                                 // R8 carry with en_p low
        d_p = 1'b1;
        tick();                                 // 9 -> 0

        // R9: out-of-range values
        d_load_n = 1'b0; d_d = 4'd12;
        tick();
        d_load_n = 1'b1; d_p = 1'b0;
        tick();
        d_p = 1'b1;
        tick();
        d_load_n = 1'b0; d_d = 4'd15;
        tick();
        d_load_n = 1'b1;
        repeat (2) tick();

        // R3: asynchronous clear acts before the edge, over a load
        d_load_n = 1'b0; d_d = 4'd7;
        tick();
        d_load_n = 1'b1;
        repeat (2) tick();
        d_clr_n = 1'b0; d_load_n = 1'b0;
        #1 check("R3 async clear", int'(d_q), 0);
        m_dq = 0;
        tick();
        d_clr_n = 1'b1; d_load_n = 1'b1;
        repeat (12) tick();

        done = 1'b1;
        report();
        $finish;
    end

endmodule